// File: doc/BRIEF.md
# Three-Target Serial Configuration Master

This block is a register-mapped SPI master that talks to as many as three clock-distribution devices sharing one serial clock and one data-out line, each with its own data-in line and chip select. Software writes one 32-bit transmit word. That word holds a data byte, a register address, a byte count, a read/write flag and a mask of the devices to address. The block sends the low 24 bits of the word as a single frame to every device whose mask bit is set, all of them at once. From each selected device it captures the byte returned during the last eight bit times, and stores it in that device's own byte lane of a receive word.

A configuration register sets the serial clock rate by a power-of-two divider. Two of its bits drive active-low reset pins of two buffer devices directly. Its upper half is a read-only view of sixteen external status inputs. A busy output is high for the whole frame. The register port is a plain word-indexed write strobe with a combinational read.

Top module: `tri_spi_master`

## Requirements
- R1: While reset is active and after it is released, all chip selects are high, SCLK is low, busy is low, both buffer reset outputs are low, and the transmit and receive registers read zero.
- R2: Register index 0 (configuration) holds a divider code in bits [2:0] and the buffer reset levels in bits 4 and 5. Bit 4 drives buf_rst_n[0] and bit 5 drives buf_rst_n[1]. Bits 3 and [15:6] read zero.
- R3: With divider code d, each SCLK half period lasts 2^d clock cycles, so busy stays high for exactly 48·2^d cycles. The code is captured when the frame starts.
- R4: A write to register index 1 (transmit) while idle starts a frame, and busy is high from the next cycle until the chip selects are released.
- R5: MOSI carries transmit bits [23:0], most significant first, in SPI mode 0. The first bit is valid before the first rising SCLK edge, MOSI changes only on falling edges, and it is stable at every rising edge.
- R6: cs_n[i] is low for the whole frame exactly when transmit bit 24+i is set. Any subset may be selected, including none. All chip selects are high while idle.
- R7: Register index 2 (receive) holds the byte from miso[0] in [7:0], from miso[1] in [15:8] and from miso[2] in [23:16]. Each byte is sampled on the rising edges of bits 16 to 23, most significant first. Bits [31:24] read zero.
- R8: The receive lanes change only at the end of a frame, and only the lanes of selected devices change. The other lanes keep their values.
- R9: A transmit write while busy is ignored, including one in the cycle in which the frame ends. The running frame's data, length and chip selects are unchanged, and no new frame follows.
- R10: Configuration bits [31:16] always read the status inputs. Writes to those bits have no effect.
- R11: Register index 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| status_in | input | 16 | External status inputs (bit 3 = PLL lock) |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to devices |
| miso | input | 3 | Serial data from each device |
| cs_n | output | 3 | Active-low chip selects |
| buf_rst_n | output | 2 | Active-low buffer resets |

## Verification
Two events can fall in the same clock cycle: the frame completing and a new transmit write arriving. The bench provokes this by counting busy cycles and driving a transmit write in the very last busy cycle. It judges the result by checking that busy then stays low, that no further SCLK edges occur, and that the receive lanes carry only the finished frame's bytes. A write in the middle of a frame is judged the same way, and in addition the captured MOSI bit stream must still equal the original word.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 2'd0,
    REG_TX   = 2'd1,
    REG_RX   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // transmit word layout
  localparam int TX_FRAME_W = 24;
  localparam int TX_SEL_LSB = 24;
  // configuration word layout
  localparam int CFG_RST_LSB  = 4;
  localparam int CFG_STAT_LSB = 16;
endpackage

// File: rtl/tsm_halftick.sv
module tsm_halftick #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [CNT_W:0]   span;

  always_comb begin
    span = (CNT_W+1)'(1) << code;
    lim  = span[CNT_W-1:0] - CNT_W'(1);
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tsm_frame.sv
module tsm_frame #(
  parameter int NUM_DEV    = 3,
  parameter int FRAME_BITS = 24,
  parameter int RX_BITS    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [FRAME_BITS-1:0]      frame_in,
  input  logic [NUM_DEV-1:0]         sel_in,
  input  logic                       tick,
  input  logic [NUM_DEV-1:0]         miso,
  output logic                       busy,
  output logic                       sclk,
  output logic                       mosi,
  output logic [NUM_DEV-1:0]         cs_n,
  output logic                       done,
  output logic [NUM_DEV-1:0]         sel,
  output logic [NUM_DEV*RX_BITS-1:0] cap
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] CAP_FROM = BIT_W'(FRAME_BITS - RX_BITS);

  logic                  busy_q, busy_d, sclk_q, sclk_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [NUM_DEV-1:0]    sel_q, sel_d;
  logic                  rise, fall, cap_en;

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    sel_d  = sel_q;
    rise   = busy_q && tick && !sclk_q;
    fall   = busy_q && tick && sclk_q;
    done   = fall && (bit_q == LAST_BIT);
    cap_en = rise && (bit_q >= CAP_FROM);
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      sh_d   = frame_in;
      bit_d  = '0;
      sel_d  = sel_in;
    end else if (rise) begin
      sclk_d = 1'b1;
    end else if (fall) begin
      sclk_d = 1'b0;
      if (done) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + BIT_W'(1);
        sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      sel_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      sel_q  <= sel_d;
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_lane
    logic [RX_BITS-1:0] cap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_en) cap_q <= {cap_q[RX_BITS-2:0], miso[i]};
    end
    assign cap[i*RX_BITS +: RX_BITS] = cap_q;
    assign cs_n[i] = !(busy_q && sel_q[i]);
  end

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = busy_q && sh_q[FRAME_BITS-1];
  assign sel  = sel_q;
endmodule

// File: rtl/tri_spi_master.sv
module tri_spi_master
  import tsm_pkg::*;
#(
  parameter int NUM_DEV    = 3,
  parameter int FRAME_BITS = 24,
  parameter int RX_BITS    = 8,
  parameter int DIV_W      = 3,
  parameter int STAT_W     = 16,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] status_in,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic [NUM_DEV-1:0] miso,
  output logic [NUM_DEV-1:0] cs_n,
  output logic [1:0]        buf_rst_n
);
  localparam int RX_W     = NUM_DEV * RX_BITS;
  localparam int RX_PAD   = DATA_W - RX_W;
  localparam int GAP_LO_W = CFG_RST_LSB - DIV_W;
  localparam int GAP_HI_W = CFG_STAT_LSB - CFG_RST_LSB - 2;
  localparam int TX_PAD   = DATA_W - TX_FRAME_W - NUM_DEV;

  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  logic [DIV_W-1:0]   div_q, div_d, div_run_q, div_run_d;
  logic [1:0]         brst_q, brst_d;
  logic [TX_FRAME_W+NUM_DEV-1:0] tx_q, tx_d;
  logic [RX_W-1:0]    rx_q, rx_d;
  logic               wr_cfg, start, tick, done, busy_i;
  logic [NUM_DEV-1:0] sel;
  logic [RX_W-1:0]    cap;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign wr_cfg = reg_we && (reg_addr == REG_CFG);
  assign start  = reg_we && (reg_addr == REG_TX) && !busy_i;

  always_comb begin
    div_d     = wr_cfg ? reg_wdata[DIV_W-1:0] : div_q;
    brst_d    = wr_cfg ? reg_wdata[CFG_RST_LSB +: 2] : brst_q;
    tx_d      = start ? reg_wdata[TX_FRAME_W+NUM_DEV-1:0] : tx_q;
    div_run_d = start ? div_q : div_run_q;
    rx_d      = rx_q;
    for (int i = 0; i < NUM_DEV; i++)
      if (done && sel[i]) rx_d[i*RX_BITS +: RX_BITS] = cap[i*RX_BITS +: RX_BITS];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      div_q     <= '0;
      div_run_q <= '0;
      brst_q    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else begin
      div_q     <= div_d;
      div_run_q <= div_run_d;
      brst_q    <= brst_d;
      tx_q      <= tx_d;
      rx_q      <= rx_d;
    end
  end

  tsm_halftick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .run(busy_i), .code(div_run_q), .tick(tick)
  );

  tsm_frame #(.NUM_DEV(NUM_DEV), .FRAME_BITS(TX_FRAME_W), .RX_BITS(RX_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .frame_in(reg_wdata[TX_FRAME_W-1:0]),
    .sel_in(reg_wdata[TX_SEL_LSB +: NUM_DEV]),
    .tick(tick), .miso(miso), .busy(busy_i), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .done(done), .sel(sel), .cap(cap)
  );

  always_comb begin
    unique case (reg_addr)
      REG_CFG:  reg_rdata = {status_in, {GAP_HI_W{1'b0}}, brst_q, {GAP_LO_W{1'b0}}, div_q};
      REG_TX:   reg_rdata = {{TX_PAD{1'b0}}, tx_q};
      REG_RX:   reg_rdata = {{RX_PAD{1'b0}}, rx_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign busy      = busy_i;
  assign buf_rst_n = brst_q;
endmodule

// File: rtl/tsm_chk.sv
module tsm_chk #(
  parameter int NUM_DEV = 3,
  parameter int STAT_W  = 16,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [STAT_W-1:0]  status_in,
  input logic               busy,
  input logic               sclk,
  input logic               mosi,
  input logic [NUM_DEV-1:0] cs_n
);
  a_r6_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == {NUM_DEV{1'b1}}));
  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r6_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));
  a_r5_mosi_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  a_r8_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && reg_addr == 2'd2 && $past(reg_addr) == 2'd2) |-> $stable(reg_rdata));
  a_r7_rx_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[31:24] == 8'h00));
  a_r10_status_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[31:16] == status_in));
  a_r11_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));
endmodule

bind tri_spi_master tsm_chk #(.NUM_DEV(NUM_DEV), .STAT_W(STAT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .status_in(status_in), .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/tri_spi_master_tb.sv
module tri_spi_master_tb;
  logic        clk, rst_n, reg_we, busy, sclk, mosi;
  logic [1:0]  reg_addr, buf_rst_n;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] status_in;
  logic [2:0]  miso, cs_n;

  int checks, errors;
  bit done_flag;
  logic [7:0]  resp [3];
  logic [7:0]  rx_exp [3];
  logic [23:0] mosi_cap;
  int fcnt, rises;
  logic [2:0]  cur_div;
  bit cs_bad;
  logic [2:0]  cs_want;

  tri_spi_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_in(status_in),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .buf_rst_n(buf_rst_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // device model: bit fcnt presented after fcnt falling edges
  always @(negedge sclk) fcnt++;
  always @(posedge sclk) begin
    mosi_cap = {mosi_cap[22:0], mosi};
    rises++;
  end
  always_comb
    for (int i = 0; i < 3; i++)
      miso[i] = (fcnt >= 16 && fcnt < 24) ? resp[i][23-fcnt] : ~resp[i][0];

  always @(negedge clk)
    if (busy && cs_n !== ~cs_want) cs_bad = 1'b1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_exp(input logic [31:0] w, input logic [15:0] st);
    return {st, 10'b0, w[5:4], 1'b0, w[2:0]};
  endfunction

  function automatic logic [31:0] rx_word();
    return {8'h00, rx_exp[2], rx_exp[1], rx_exp[0]};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic set_cfg(input logic [31:0] w);
    reg_write(2'd0, w);
    cur_div = w[2:0];
    reg_addr = 2'd0; #1;
    check(reg_rdata == cfg_exp(w, status_in), "R2/R10 cfg readback", reg_rdata, cfg_exp(w, status_in));
    check(buf_rst_n == w[5:4], "R2 buffer resets", {30'b0, buf_rst_n}, {30'b0, w[5:4]});
    reg_addr = 2'd2;
  endtask

  // inject: 0 none, 1 mid-frame write, 2 write in final busy cycle
  task automatic run_frame(input logic [31:0] tx, input int inject);
    int cnt, len, extra;
    len = 48 << cur_div;
    for (int i = 0; i < 3; i++) resp[i] = 8'($urandom);
    fcnt = 0; rises = 0; mosi_cap = '0; cs_bad = 1'b0; cs_want = tx[26:24];
    reg_write(2'd1, tx);
    cnt = busy ? 1 : 0;
    check(busy, "R4 busy after start", {31'b0, busy}, 32'd1);
    forever begin
      if (inject == 1 && cnt == len / 2) begin
        reg_addr = 2'd1; reg_wdata = ~tx; reg_we = 1'b1;
      end else if (inject == 2 && cnt == len) begin
        reg_addr = 2'd1; reg_wdata = tx ^ 32'h00FF_FFFF; reg_we = 1'b1;
      end
      if (cnt == len / 4) begin
        #1 check(reg_rdata == rx_word(), "R8 rx unchanged mid-frame", reg_rdata, rx_word());
      end
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd2;
      if (busy) cnt++;
      else break;
      if (cnt > len + 4) break;
    end
    check(cnt == len, "R3 frame length", cnt, len);
    check(mosi_cap == tx[23:0], "R5 mosi stream", {8'b0, mosi_cap}, {8'b0, tx[23:0]});
    check(!cs_bad, "R6 chip selects during frame", {29'b0, cs_n}, {29'b0, ~tx[26:24]});
    for (int i = 0; i < 3; i++) if (tx[24+i]) rx_exp[i] = resp[i];
    #1 check(reg_rdata == rx_word(), "R7/R8 rx lanes", reg_rdata, rx_word());
    extra = rises;
    repeat (20) @(negedge clk);
    check(!busy && rises == extra && cs_n == 3'b111, "R9 no frame after ignored write",
          {busy, 28'b0, cs_n}, {1'b0, 28'b0, 3'b111});
    if (inject != 0) check(rises == 24, "R9 running frame unchanged", rises, 24);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    if (!done_flag) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    checks = 0; errors = 0; done_flag = 0;
    reg_we = 0; reg_addr = 2'd0; reg_wdata = '0; status_in = 16'h0000;
    for (int i = 0; i < 3; i++) begin resp[i] = '0; rx_exp[i] = '0; end
    fcnt = 0; rises = 0; cur_div = 0; cs_want = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n == 3'b111 && !sclk && !busy && buf_rst_n == 2'b00, "R1 in reset",
          {cs_n, sclk, busy, buf_rst_n}, {3'b111, 4'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n == 3'b111 && !sclk && !busy && buf_rst_n == 2'b00, "R1 after reset",
          {cs_n, sclk, busy, buf_rst_n}, {3'b111, 4'b0});
    reg_addr = 2'd0; #1 check(reg_rdata == 32'h0, "R1 cfg zero", reg_rdata, 0);
    reg_addr = 2'd1; #1 check(reg_rdata == 32'h0, "R1 tx zero", reg_rdata, 0);
    reg_addr = 2'd2; #1 check(reg_rdata == 32'h0, "R1 rx zero", reg_rdata, 0);
    reg_addr = 2'd3; #1 check(reg_rdata == 32'h0, "R11 hole zero", reg_rdata, 0);

    // R10: status view, writes to upper bits ignored
    status_in = 16'h0008;
    set_cfg(32'hFFFF_0031);
    status_in = 16'hA5C3;
    reg_addr = 2'd0; #1;
    check(reg_rdata[31:16] == 16'hA5C3, "R10 status follows input", reg_rdata, {16'hA5C3, 16'h0});

    // directed: all devices, fastest rate
    set_cfg(32'h0000_0030);
    run_frame(32'h0780_A55A, 0);
    // directed: no device selected, lanes keep values (R8)
    run_frame(32'h0012_3456, 0);
    // directed: single device, slowest rate
    set_cfg(32'h0000_0017);
    run_frame(32'h0200_8C31, 0);
    // R9 mid-frame write and write in final busy cycle
    set_cfg(32'h0000_0001);
    run_frame(32'h0500_1F2E, 1);
    run_frame(32'h0380_7E01, 2);

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [31:0] c, t;
      c = $urandom; c[2:0] = 3'($urandom_range(0, 3));
      status_in = 16'($urandom);
      set_cfg(c);
      t = $urandom; t[20:15] = 6'b0; t[22:21] = 2'b0; t[31:27] = 5'b0;
      run_frame(t, $urandom_range(0, 2));
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule